// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit operand into an IEEE 754 binary value. The source can be a signed or unsigned integer of 32 or 64 bits, and the result can be single or double precision. A single-precision result is rounded to 24 significant bits first. It is then widened, without loss, into the 64-bit double encoding, so the output word always has the double layout.

Each request is one operand presented with `in_valid`. One clock later the registered result appears with `out_valid`. Alongside the result come:
- two rounding status flags, one saying the magnitude was rounded up and one saying the result is inexact;
- a write-enable for those flags;
- an inexact exception indication;
- an optional 4-bit sign-test field.

Converting a 32-bit integer to double precision can never lose bits. On that path the flags are not written and no exception is indicated.

Top module: `i2f_conv`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs clear on that edge: `out_valid`=0, `out_result`=0, `out_flag_we`=0, `out_fr`=0, `out_fi`=0, `out_exc`=0 and `out_cr`=0.
- R2: A request sampled with `in_valid`=1 produces `out_valid`=1 on the next edge. A cycle with `in_valid`=0 gives `out_valid`=0, and every data output keeps its previous value.
- R3: `in_itype` selects the source: 0 is signed 32-bit, 1 is signed 64-bit, 2 is unsigned 32-bit and 3 is unsigned 64-bit. For 32-bit sources, bits 63:32 of `in_operand` have no effect on any output.
- R4: With a 32-bit source and `in_dbl`=1, the result is the exact value. `out_flag_we`, `out_fr`, `out_fi` and `out_exc` are all 0.
- R5: On every other path the value is rounded according to `in_rmode`: 0 is nearest with ties to even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity.
- R6: On a rounding path, `out_flag_we`=1. `out_fr` is 1 exactly when rounding increased the magnitude. `out_fi` is 1 exactly when any discarded bit was nonzero. `out_exc` equals `out_fi`.
- R7: With `in_dbl`=0, the result is rounded to a 24-bit significand and encoded as a double. Bits 28:0 of `out_result` are therefore zero.
- R8: A zero input produces +0.0 (all 64 bits zero) with `out_fr`=0 and `out_fi`=0.
- R9: A signed source takes its magnitude by two's complement, and this includes the most negative 32-bit and 64-bit values (results -2^31 and -2^63).
- R10: With `in_rec`=1, `out_cr` gives {less than zero, greater than zero, equal to zero, unordered} in bits 3 down to 0 for the result. The unordered bit is always 0. With `in_rec`=0, `out_cr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 64 | Integer operand |
| in_itype | input | 2 | Source integer kind (R3 encoding) |
| in_dbl | input | 1 | 1 = double result, 0 = single result widened to double |
| in_rmode | input | 2 | Rounding mode (R5 encoding) |
| in_rec | input | 1 | Produce the sign-test field |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Result in double encoding |
| out_flag_we | output | 1 | Status flags are to be written |
| out_fr | output | 1 | Magnitude was increased by rounding |
| out_fi | output | 1 | Result is inexact |
| out_exc | output | 1 | Inexact exception indication |
| out_cr | output | 4 | Sign-test field {LT, GT, EQ, UN} |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- that no flag or exception appears on the exact path;
- that a rounding-up flag never appears without the inexact flag;
- that single results carry zero low fraction bits;
- that a zero result is positive and exact;
- that the sign-test field has at most one bit set.

The numerical properties can only be shown by the bench's sweep, which runs every source kind, precision and rounding mode against arithmetic reference values. These properties are:
- correct rounding for each mode, including ties and carries into the exponent;
- the exact inexact and round-up flag values;
- that the upper operand bits are ignored for 32-bit sources;
- the correct handling of the most negative values.

// File: rtl/i2f_pkg.sv
// Shared constants and encodings for the integer-to-float converter.
// Assumes a 64-bit operand and IEEE 754 binary64/binary32 targets.
package i2f_pkg;
    localparam int OP_W      = 64;
    localparam int DP_PREC   = 53;
    localparam int SP_PREC   = 24;
    localparam int DP_EXP_W  = 11;
    localparam int DP_BIAS   = 1023;
    localparam int LZ_W      = $clog2(OP_W) + 1;
    localparam int DP_DROP   = OP_W - DP_PREC;
    localparam int SP_DROP   = OP_W - SP_PREC;
    localparam int SP_PAD    = DP_PREC - SP_PREC;

    typedef enum logic [1:0] {
        SRC_S32 = 2'd0,
        SRC_S64 = 2'd1,
        SRC_U32 = 2'd2,
        SRC_U64 = 2'd3
    } src_kind_e;

    typedef enum logic [1:0] {
        RND_NEAR  = 2'd0,
        RND_ZERO  = 2'd1,
        RND_UP    = 2'd2,
        RND_DOWN  = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/i2f_extract.sv
// Sign and magnitude extraction. Picks the source width from the kind
// select and takes the two's-complement magnitude of signed sources.
// Assumes 32-bit sources live in the low half of the operand.
module i2f_extract
    import i2f_pkg::*;
(
    input  logic [OP_W-1:0] operand,
    input  logic [1:0]      kind,
    output logic            sign,
    output logic            narrow,
    output logic [OP_W-1:0] mag
);
    localparam int HALF = OP_W / 2;

    logic [OP_W-1:0] wide;

    // Select the source value and its sign bit according to the kind.
    always_comb begin
        narrow = (kind == SRC_S32) || (kind == SRC_U32);
        case (kind)
            SRC_S32: begin
                wide = {{HALF{operand[HALF-1]}}, operand[HALF-1:0]};
                sign = operand[HALF-1];
            end
            SRC_U32: begin
                wide = {{HALF{1'b0}}, operand[HALF-1:0]};
                sign = 1'b0;
            end
            SRC_S64: begin
                wide = operand;
                sign = operand[OP_W-1];
            end
            default: begin
                wide = operand;
                sign = 1'b0;
            end
        endcase
        mag = sign ? (~wide + 1'b1) : wide;
    end
endmodule

// File: rtl/i2f_normalize.sv
// Leading-zero count and left normalization of an unsigned magnitude.
// Assumes W is a power of two; a zero input reports zero with lz = 0.
module i2f_normalize #(
    parameter int W = 64
) (
    input  logic [W-1:0]           mag,
    output logic [W-1:0]           norm,
    output logic [$clog2(W):0]     lz,
    output logic                   is_zero
);
    localparam int LW = $clog2(W) + 1;

    // Find the highest set bit; the last hit in an ascending scan wins.
    always_comb begin
        lz = '0;
        for (int i = 0; i < W; i++) begin
            if (mag[i]) lz = LW'(W - 1 - i);
        end
        is_zero = (mag == '0);
        norm    = mag << lz;
    end
endmodule

// File: rtl/i2f_round.sv
// Rounds a normalized magnitude to 53 or 24 significant bits and packs
// the result into the binary64 layout. Assumes norm has its top bit set
// unless is_zero; no overflow is possible from a 64-bit integer.
module i2f_round
    import i2f_pkg::*;
(
    input  logic [OP_W-1:0] norm,
    input  logic [LZ_W-1:0] lz,
    input  logic            is_zero,
    input  logic            sign,
    input  logic            dbl,
    input  logic [1:0]      rmode,
    output logic [OP_W-1:0] packed_fp,
    output logic            bumped,
    output logic            inexact
);
    logic [DP_PREC-1:0]  kept;
    logic                guard;
    logic                sticky;
    logic                up;
    logic [DP_PREC:0]    sum;
    logic                carry;
    logic [DP_EXP_W-1:0] expo;
    logic [DP_PREC-2:0]  frac;

    // Split the normalized value into kept bits, guard and sticky.
    always_comb begin
        if (dbl) begin
            kept   = norm[OP_W-1:DP_DROP];
            guard  = norm[DP_DROP-1];
            sticky = |norm[DP_DROP-2:0];
        end else begin
            kept   = {{SP_PAD{1'b0}}, norm[OP_W-1:SP_DROP]};
            guard  = norm[SP_DROP-1];
            sticky = |norm[SP_DROP-2:0];
        end
    end

    // Decide whether the magnitude is incremented under the mode.
    always_comb begin
        case (rmode)
            RND_NEAR: up = guard & (sticky | kept[0]);
            RND_ZERO: up = 1'b0;
            RND_UP:   up = ~sign & (guard | sticky);
            default:  up = sign & (guard | sticky);
        endcase
        if (is_zero) up = 1'b0;
        inexact = ~is_zero & (guard | sticky);
        bumped  = up;
    end

    // Add the increment, fold a carry into the exponent and pack.
    always_comb begin
        sum   = {1'b0, kept} + {{DP_PREC{1'b0}}, up};
        carry = dbl ? sum[DP_PREC] : sum[SP_PREC];
        expo  = DP_EXP_W'(DP_BIAS + OP_W - 1) - DP_EXP_W'(lz) + DP_EXP_W'(carry);
        if (carry)
            frac = '0;
        else if (dbl)
            frac = sum[DP_PREC-2:0];
        else
            frac = {sum[SP_PREC-2:0], {SP_PAD{1'b0}}};
        packed_fp = is_zero ? '0 : {sign, expo, frac};
    end

    // Single results must leave the widened fraction tail clear (R7).
    always_comb begin
        if (!dbl && !$isunknown(packed_fp))
            assert_single_tail_R7: assert (packed_fp[SP_PAD-1:0] == '0);
    end
endmodule

// File: rtl/i2f_conv.sv
// Integer to floating-point converter top. One registered stage: a
// request with in_valid yields a result with out_valid one cycle later.
// Assumes rst_n is synchronous and active low.
module i2f_conv
    import i2f_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [63:0]     in_operand,
    input  logic [1:0]      in_itype,
    input  logic            in_dbl,
    input  logic [1:0]      in_rmode,
    input  logic            in_rec,
    output logic            out_valid,
    output logic [63:0]     out_result,
    output logic            out_flag_we,
    output logic            out_fr,
    output logic            out_fi,
    output logic            out_exc,
    output logic [3:0]      out_cr
);
    logic            sign;
    logic            narrow;
    logic [OP_W-1:0] mag;
    logic [OP_W-1:0] norm;
    logic [LZ_W-1:0] lz;
    logic            is_zero;
    logic [OP_W-1:0] fp;
    logic            bumped;
    logic            inexact;
    logic            exact_path;
    logic            nonzero;
    logic [3:0]      cr_next;

    i2f_extract u_extract (
        .operand (in_operand),
        .kind    (in_itype),
        .sign    (sign),
        .narrow  (narrow),
        .mag     (mag)
    );

    i2f_normalize #(.W(OP_W)) u_norm (
        .mag     (mag),
        .norm    (norm),
        .lz      (lz),
        .is_zero (is_zero)
    );

    i2f_round u_round (
        .norm      (norm),
        .lz        (lz),
        .is_zero   (is_zero),
        .sign      (sign),
        .dbl       (in_dbl),
        .rmode     (in_rmode),
        .packed_fp (fp),
        .bumped    (bumped),
        .inexact   (inexact)
    );

    // Build the sign-test field from the packed result when requested.
    always_comb begin
        exact_path = narrow & in_dbl;
        nonzero    = |fp[OP_W-2:0];
        cr_next    = in_rec ? {fp[OP_W-1] & nonzero, ~fp[OP_W-1] & nonzero, ~nonzero, 1'b0}
                            : 4'b0000;
    end

    // Output register: load on a request, hold data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_flag_we <= 1'b0;
            out_fr      <= 1'b0;
            out_fi      <= 1'b0;
            out_exc     <= 1'b0;
            out_cr      <= 4'b0000;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= fp;
                out_flag_we <= ~exact_path;
                out_fr      <= ~exact_path & bumped;
                out_fi      <= ~exact_path & inexact;
                out_exc     <= ~exact_path & inexact;
                out_cr      <= cr_next;
            end
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_exact_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_flag_we) |-> (!out_fr && !out_fi && !out_exc));

    assert_bump_needs_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_fr |-> out_fi);

    assert_zero_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[62:0] == '0) |-> (!out_result[63] && !out_fi));

    assert_cr_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_cr));
endmodule

// File: tb/i2f_conv_test.sv
module i2f_conv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_itype = '0;
    logic        in_dbl = 1'b0;
    logic [1:0]  in_rmode = '0;
    logic        in_rec = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_flag_we, out_fr, out_fi, out_exc;
    logic [3:0]  out_cr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    i2f_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_itype(in_itype), .in_dbl(in_dbl), .in_rmode(in_rmode), .in_rec(in_rec),
        .out_valid(out_valid), .out_result(out_result), .out_flag_we(out_flag_we),
        .out_fr(out_fr), .out_fi(out_fi), .out_exc(out_exc), .out_cr(out_cr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h (op=%h kind=%0d dbl=%0d rm=%0d)",
                     req, act, exp, in_operand, in_itype, in_dbl, in_rmode);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x ^= x << 13;
        x ^= x >> 7;
        x ^= x << 17;
        return x;
    endfunction

    // Arithmetic reference: result, round-up flag, inexact flag, flag write.
    task automatic model(input logic [63:0] op, input logic [1:0] kind, input logic dbl,
                         input logic [1:0] rm, output logic [63:0] res,
                         output logic fr, output logic fi, output logic we);
        logic        s;
        logic [63:0] m, q, rem, half;
        int          msb, prec, sh, e;
        logic        up;
        case (kind)
            2'd0: begin s = op[31]; m = s ? 64'(-{{32{op[31]}}, op[31:0]}) : {32'b0, op[31:0]}; end
            2'd1: begin s = op[63]; m = s ? -op : op; end
            2'd2: begin s = 1'b0; m = {32'b0, op[31:0]}; end
            default: begin s = 1'b0; m = op; end
        endcase
        we = !(((kind == 2'd0) || (kind == 2'd2)) && dbl);
        prec = dbl ? 53 : 24;
        res = '0; fr = 1'b0; fi = 1'b0;
        if (m != 0) begin
            msb = 0;
            for (int i = 0; i < 64; i++) if (m[i]) msb = i;
            if (msb < prec) begin
                sh = 0; q = m; rem = 0; half = 0;
            end else begin
                sh = msb - prec + 1;
                q = m >> sh;
                rem = m & ((64'd1 << sh) - 1);
                half = 64'd1 << (sh - 1);
            end
            case (rm)
                2'd0: up = (rem > half) || ((rem == half) && (rem != 0) && q[0]);
                2'd1: up = 1'b0;
                2'd2: up = !s && (rem != 0);
                default: up = s && (rem != 0);
            endcase
            q = q + 64'(up);
            e = msb;
            if (q == (64'd1 << prec)) begin q = q >> 1; e = e + 1; end
            q = q << (53 - prec);
            q = q << (53 - 1 - msb > 0 && prec > msb ? (prec - 1 - msb) : 0);
            res = {s, 11'(e + 1023), q[51:0]};
            fr = up && we;
            fi = (rem != 0) && we;
        end
    endtask

    task automatic run_one(input logic [63:0] op, input logic [1:0] kind, input logic dbl,
                           input logic [1:0] rm, input logic rec);
        logic [63:0] er, held;
        logic efr, efi, ewe;
        logic [3:0] ecr;
        string tag;
        model(op, kind, dbl, rm, er, efr, efi, ewe);
        if (!rec) ecr = 4'b0;
        else if (er[62:0] == 0) ecr = 4'b0010;
        else ecr = er[63] ? 4'b1000 : 4'b0100;
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_itype = kind; in_dbl = dbl;
        in_rmode = rm; in_rec = rec;
        @(negedge clk);
        if ((kind[0] == 1'b0) && op[63:32] != 0 && op[31:0] == 0) tag = "R3";
        else if (er == 0) tag = "R8";
        else if (er == 64'hC1E0_0000_0000_0000 || er == 64'hC3E0_0000_0000_0000) tag = "R9";
        else if (!ewe) tag = "R4";
        else if (!dbl) tag = "R7";
        else tag = "R5";
        cmp({tag, " result"}, out_result, er);
        cmp("R2 valid", {63'b0, out_valid}, 64'd1);
        cmp(ewe ? "R6 flags" : "R4 flags", {60'b0, out_flag_we, out_fr, out_fi, out_exc},
            {60'b0, ewe, efr, efi, efi});
        cmp("R10 cr", {60'b0, out_cr}, {60'b0, ecr});
        held = out_result;
        in_valid = 1'b0; in_operand = ~op;
        @(negedge clk);
        cmp("R2 idle", {63'b0, out_valid}, 64'd0);
        cmp("R2 hold", out_result, held);
    endtask

    function automatic logic [63:0] pattern(input int k);
        case (k)
            0: return 64'd0;
            1: return 64'd1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h8000_0000_0000_0000;
            5: return 64'h7FFF_FFFF_FFFF_FFFF;
            6: return 64'h0000_0000_7FFF_FFFF;
            7: return 64'h0000_0000_0100_0001;
            8: return 64'h0000_0000_0100_0003;
            9: return 64'h0020_0000_0000_0001;
            10: return 64'h0020_0000_0000_0003;
            11: return 64'h0000_0000_00FF_FFFF;
            12: return 64'h0000_0000_01FF_FFFF;
            13: return 64'h003F_FFFF_FFFF_FFFF;
            14: return 64'hDEAD_BEEF_0000_0000;
            15: return 64'h1234_5678_FFFF_FFFF;
            16: return 64'hFFFF_FFFF_8000_0001;
            17: return 64'h0000_0000_0180_0000;
            18: return 64'h0000_0000_0080_0001;
            default: return 64'hFFFF_FFFF_FF00_0001;
        endcase
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        cmp("R1 valid", {63'b0, out_valid}, 64'd0);
        cmp("R1 result", out_result, 64'd0);
        cmp("R1 flags", {59'b0, out_flag_we, out_fr, out_fi, out_exc, 1'b0}, 64'd0);
        cmp("R1 cr", {60'b0, out_cr}, 64'd0);
        rst_n = 1'b1;
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int k = 0; k < 60; k++) begin
                logic [63:0] op;
                if (k < 20) op = pattern(k);
                else begin
                    lfsr = next_rand(lfsr);
                    op = lfsr >> lfsr[5:0];
                    if (k[0]) op = op ^ {lfsr[63:32], 32'b0};
                end
                run_one(op, 2'(cfg >> 3), cfg[2], 2'(cfg), k[1]);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule